// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write Loader

This block models the write side of a byte-wide paged nonvolatile memory. It runs on a fast system clock. Three active-low strobes arrive asynchronously: chip select, write strobe and output strobe. The block synchronizes them and finds their edges on the clock.

A write is armed when chip select and write strobe are both low while the output strobe is high. The byte address is taken when the second of the two falls. The data byte is taken when the first of the two rises.

The first accepted byte opens a load window and fixes the page. The page is the address bits at and above the in-page index. Further bytes of the same page may follow, in any order and with overwrites. Each must arrive before an idle counter expires.

When the window closes, a timed programming cycle starts. It copies only the byte slots that were loaded into a simple array model. All other bytes of the page keep their old contents. A separate read port lets the surrounding logic see the array contents. A read strobe during the busy period is flagged as a status poll.

Top module: `page_write_loader`

## Requirements
- R1: After reset, `busy`, `page_err` and `poll` are 0 and every array byte reads 8'hFF.
- R2: A byte is taken only when chip select and write strobe are both low and the output strobe is high. A strobe pair asserted while the output strobe is low writes nothing and does not set `busy`.
- R3: The address is the one present when the second of the two write strobes falls, so address changes after that point are ignored. The data is the one present when the first strobe rises, so data changes while both strobes are low are taken.
- R4: `busy` goes to 1 on the clock edge that accepts the first byte of a page. It stays 1 through loading and programming.
- R5: Each accepted byte restarts the idle window of `LOAD_TO` cycles. Programming begins `LOAD_TO` edges after the last accepted byte.
- R6: Programming lasts exactly `WC_CYC` edges, after which `busy` returns to 0.
- R7: Bytes of a page may be loaded in any order. A second load of the same slot within the window replaces the first value.
- R8: Only loaded slots are written. All other bytes of the array keep their previous values.
- R9: A byte whose page bits (address bits from `PAGE_W` upward) differ from those of the first byte is dropped. It sets `page_err`, and `page_err` stays 1 until reset.
- R10: Write strobes that begin while programming is under way are ignored.
- R11: `poll` is 1 while `busy` is 1 and the synchronized strobes show a read: chip select low, output strobe low, write strobe high. `poll` is 0 when the block is idle.
- R12: A full page of `2**PAGE_W` bytes can be loaded in one window, and all of its bytes are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Asynchronous chip select, active low |
| we_n | input | 1 | Asynchronous write strobe, active low |
| oe_n | input | 1 | Asynchronous output strobe, active low |
| addr | input | ADDR_W | Byte address bus |
| din | input | 8 | Write data bus |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array contents at `rd_addr` |
| busy | output | 1 | Loading or programming in progress |
| poll | output | 1 | Read strobe observed while busy |
| page_err | output | 1 | Sticky flag for a byte from the wrong page |

## Verification
The bench builds the block with `ADDR_W=8`, `PAGE_W=3`, `LOAD_TO=40` and `WC_CYC=30`. This gives 8-byte pages, so a full page, out-of-order loads and overwrites all fit in a short run. The windows are short enough that the bench can write a second page after a timeout. It can also place a strobe wholly inside a programming cycle, and check the exact edges where `busy` rises and falls.

// File: rtl/epl_pkg.sv
// Shared types for the paged write loader.
// Assumes: nothing beyond standard SystemVerilog.
package epl_pkg;

    // Phase of the write engine.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_t;

endpackage

// File: rtl/epl_strobe_sync.sv
// Strobe front end: brings the three asynchronous strobes into the clock
// domain with two flops each and finds the write-window edges.
// Assumes: addr is stable from before the second strobe falls until its
// capture edge. din is stable from the first rising strobe until the
// synchronized edge is seen (about three clocks).
module epl_strobe_sync #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              accept,
    output logic              byte_done,
    output logic [ADDR_W-1:0] byte_addr,
    output logic              read_seen
);

    logic [2:0] sync1, sync2;   // bit0 ce_n, bit1 we_n, bit2 oe_n
    logic       win_prev;
    logic       armed;
    logic       win_now, oe_high, win_rise, win_fall;

    // Two-stage synchronizer and previous-window register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1    <= 3'b111;
            sync2    <= 3'b111;
            win_prev <= 1'b0;
        end else begin
            sync1    <= {oe_n, we_n, ce_n};
            sync2    <= sync1;
            win_prev <= win_now;
        end
    end

    // Decode the synchronized strobe levels and window edges.
    always_comb begin
        win_now  = ~sync2[0] & ~sync2[1];
        oe_high  = sync2[2];
        win_rise = win_now & ~win_prev;
        win_fall = ~win_now & win_prev;
    end

    // Arm on the later falling strobe and take the address there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            byte_addr <= '0;
        end else if (win_rise && oe_high && accept) begin
            armed     <= 1'b1;
            byte_addr <= addr;
        end else if (!oe_high || win_fall) begin
            armed     <= 1'b0;
        end
    end

    assign byte_done = win_fall & armed & oe_high;
    assign read_seen = ~sync2[0] & ~sync2[2] & sync2[1];

endmodule

// File: rtl/epl_page_buf.sv
// Page buffer: one data byte and one valid bit per slot of a page.
// Assumes: write and clear are not asserted in the same cycle.
module epl_page_buf #(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              clr,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);

    localparam int SLOTS = 1 << PAGE_W;

    logic [7:0]       slot_data [SLOTS];
    logic [SLOTS-1:0] slot_valid;

    // Store a loaded byte. A later load of the same slot overwrites it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) slot_data[i] <= 8'h00;
        end else if (wr_en) begin
            slot_data[wr_idx] <= wr_data;
        end
    end

    // Track which slots hold loaded data.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            slot_valid <= '0;
        end else if (wr_en) begin
            slot_valid[wr_idx] <= 1'b1;
        end
    end

    assign rd_data  = slot_data[rd_idx];
    assign rd_valid = slot_valid[rd_idx];

endmodule

// File: rtl/epl_seq.sv
// Write engine: owns the load window, page check and programming timer.
// While programming it walks the page slots, one per cycle.
// Assumes: WC_CYC >= 2**PAGE_W, so the walk ends inside the cycle.
module epl_seq
    import epl_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int PAGE_W  = 7,
    parameter int LOAD_TO = 15000,
    parameter int WC_CYC  = 1000000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     byte_done,
    input  logic [ADDR_W-1:0]        byte_addr,
    input  logic                     slot_valid,
    output logic                     accept,
    output logic                     buf_we,
    output logic                     buf_clr,
    output logic [PAGE_W-1:0]        scan_idx,
    output logic                     arr_we,
    output logic [ADDR_W-1:0]        arr_addr,
    output logic                     busy,
    output logic                     prog_on,
    output logic                     page_err
);

    localparam int MAXC  = (LOAD_TO > WC_CYC) ? LOAD_TO : WC_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int PG_W  = ADDR_W - PAGE_W;
    localparam int SLOTS = 1 << PAGE_W;

    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [PG_W-1:0]   page_q;
    logic              same_page;
    logic              load_end, prog_end;

    // Decode the page match and the counter limits.
    always_comb begin
        same_page = (byte_addr[ADDR_W-1:PAGE_W] == page_q);
        load_end  = (cnt == CNT_W'(LOAD_TO - 1));
        prog_end  = (cnt == CNT_W'(WC_CYC - 1));
    end

    // Phase, window counter, page register and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            page_q   <= '0;
            page_err <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (byte_done) begin
                    phase  <= PH_LOAD;
                    cnt    <= '0;
                    page_q <= byte_addr[ADDR_W-1:PAGE_W];
                end
                PH_LOAD: begin
                    if (byte_done && same_page) begin
                        cnt <= '0;
                    end else begin
                        if (byte_done) page_err <= 1'b1;
                        if (load_end) begin
                            phase <= PH_PROG;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_PROG: begin
                    if (prog_end) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Buffer control and the slot walk of the programming cycle.
    always_comb begin
        accept   = (phase != PH_PROG);
        buf_we   = byte_done && ((phase == PH_IDLE) || ((phase == PH_LOAD) && same_page));
        buf_clr  = (phase == PH_PROG) && prog_end;
        scan_idx = cnt[PAGE_W-1:0];
        arr_we   = (phase == PH_PROG) && (cnt < CNT_W'(SLOTS)) && slot_valid;
        arr_addr = {page_q, scan_idx};
        busy     = (phase != PH_IDLE);
        prog_on  = (phase == PH_PROG);
    end

endmodule

// File: rtl/epl_array.sv
// Array model: byte storage that starts erased (all ones) after reset.
// Assumes: one write port and one asynchronous read port are enough.
module epl_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    // Erase on reset and write one programmed byte per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/page_write_loader.sv
// Top of the paged write loader. It joins the strobe front end, the page
// buffer, the write engine and the array model.
// Assumes: the strobes are asynchronous and clk is much faster than them.
module page_write_loader #(
    parameter int ADDR_W  = 10,
    parameter int PAGE_W  = 7,
    parameter int LOAD_TO = 15000,
    parameter int WC_CYC  = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              poll,
    output logic              page_err
);

    logic              byte_done, read_seen, accept;
    logic [ADDR_W-1:0] byte_addr, arr_addr;
    logic              buf_we, buf_clr, slot_valid, arr_we, prog_on;
    logic [PAGE_W-1:0] scan_idx;
    logic [7:0]        slot_data;

    epl_strobe_sync #(.ADDR_W(ADDR_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .accept(accept), .byte_done(byte_done),
        .byte_addr(byte_addr), .read_seen(read_seen)
    );

    epl_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(buf_we),
        .wr_idx(byte_addr[PAGE_W-1:0]), .wr_data(din), .clr(buf_clr),
        .rd_idx(scan_idx), .rd_data(slot_data), .rd_valid(slot_valid)
    );

    epl_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LOAD_TO(LOAD_TO), .WC_CYC(WC_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_addr(byte_addr),
        .slot_valid(slot_valid), .accept(accept), .buf_we(buf_we),
        .buf_clr(buf_clr), .scan_idx(scan_idx), .arr_we(arr_we),
        .arr_addr(arr_addr), .busy(busy), .prog_on(prog_on), .page_err(page_err)
    );

    epl_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_addr),
        .wdata(slot_data), .raddr(rd_addr), .rdata(rd_data)
    );

    // A read strobe during the busy period is a status poll.
    assign poll = busy & read_seen;

endmodule

// File: rtl/page_write_loader_chk.sv
// Checker for page_write_loader: temporal rules between the write engine,
// the buffer and the array port. It is attached with bind below.
module page_write_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic page_err,
    input logic prog_on,
    input logic arr_we,
    input logic buf_we
);

    // R9: the page error flag never clears without reset.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err);

    // R10: no byte enters the buffer while programming.
    assert_no_load_in_prog_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_on |-> !buf_we);

    // R8: the array changes only during programming.
    assert_array_write_in_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> prog_on);

    // R4: busy rises only on an edge that stored a byte.
    assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(buf_we));

    // R6: busy drops only at the end of programming.
    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(prog_on));

    // R5: programming starts from an open window on an edge with no byte.
    assert_prog_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_on) |-> ($past(busy) && !$past(buf_we)));

endmodule

bind page_write_loader page_write_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .page_err(page_err),
    .prog_on(prog_on), .arr_we(arr_we), .buf_we(buf_we)
);

// File: tb/page_write_loader_bench.sv
// Bench for page_write_loader. A behavioural model runs beside the design,
// and busy, poll and page_err are compared on every clock.
module page_write_loader_bench;

    localparam int AW   = 8;
    localparam int PW   = 3;
    localparam int LTO  = 40;
    localparam int WCC  = 30;
    localparam int PG   = 1 << PW;
    localparam int DEP  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy, poll, page_err;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    page_write_loader #(.ADDR_W(AW), .PAGE_W(PW), .LOAD_TO(LTO), .WC_CYC(WCC)) u_page_write_loader (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .poll(poll), .page_err(page_err)
    );

    always #5 clk = ~clk;

    // Behavioural model state.
    int  mem_ref [DEP];
    int  buf_ref [int];
    int  m_phase = 0;            // 0 idle, 1 loading, 2 programming
    int  m_cnt = 0;
    int  m_page = 0;
    bit  m_err = 0;
    bit  m_armed = 0;
    int  m_addr = 0;
    bit  v1_ce = 1, v1_we = 1, v1_oe = 1;   // strobe view one edge old
    bit  v2_ce = 1, v2_we = 1, v2_oe = 1;   // strobe view two edges old
    bit  w_prev = 0;

    initial for (int i = 0; i < DEP; i++) mem_ref[i] = 8'hFF;

    // Model step on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_err = 0; m_armed = 0; w_prev = 0;
            v1_ce = 1; v1_we = 1; v1_oe = 1; v2_ce = 1; v2_we = 1; v2_oe = 1;
            buf_ref.delete();
        end else begin
            bit w_now, rise, fall, got;
            w_now = !v2_ce && !v2_we;
            rise  = w_now && !w_prev;
            fall  = !w_now && w_prev;
            got   = fall && m_armed && v2_oe;
            if (rise && v2_oe && m_phase != 2) begin
                m_armed = 1; m_addr = int'(addr);
            end else if (!v2_oe || fall) begin
                m_armed = 0;
            end
            case (m_phase)
                0: if (got) begin
                    m_phase = 1; m_cnt = 0; m_page = m_addr / PG;
                    buf_ref[m_addr % PG] = int'(din);
                end
                1: begin
                    if (got && (m_addr / PG == m_page)) begin
                        buf_ref[m_addr % PG] = int'(din); m_cnt = 0;
                    end else begin
                        if (got) m_err = 1;
                        if (m_cnt == LTO - 1) begin m_phase = 2; m_cnt = 0; end
                        else m_cnt++;
                    end
                end
                default: begin
                    if (m_cnt == WCC - 1) begin
                        foreach (buf_ref[k]) mem_ref[m_page * PG + k] = buf_ref[k];
                        buf_ref.delete();
                        m_phase = 0; m_cnt = 0;
                    end else m_cnt++;
                end
            endcase
            w_prev = w_now;
            v2_ce = v1_ce; v2_we = v1_we; v2_oe = v1_oe;
            v1_ce = ce_n;  v1_we = we_n;  v1_oe = oe_n;
        end
    end

    // Compare the status outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            bit eb, ep;
            eb = (m_phase != 0);
            ep = eb && !v2_ce && !v2_oe && v2_we;
            checks += 3;
            if (busy !== eb) begin
                failures++;
                $display("FAIL R4/R5/R6 busy actual=%0b expected=%0b t=%0t", busy, eb, $time);
            end
            if (page_err !== m_err) begin
                failures++;
                $display("FAIL R9 page_err actual=%0b expected=%0b t=%0t", page_err, m_err, $time);
            end
            if (poll !== ep) begin
                failures++;
                $display("FAIL R11 poll actual=%0b expected=%0b t=%0t", poll, ep, $time);
            end
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input string tag, input int a);
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        check_eq(tag, int'(rd_data), mem_ref[a]);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = AW'(a); din = 8'(d); oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while ((busy || m_phase != 0) && n < 1000) begin
            @(negedge clk); n++;
        end
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check_eq("R1 busy", int'(busy), 0);
        check_eq("R1 page_err", int'(page_err), 0);
        check_eq("R1 poll", int'(poll), 0);
        read_chk("R1 erased", 8'h00);
        read_chk("R1 erased", 8'hFF);

        // R2: strobes with the output strobe low do nothing.
        @(negedge clk);
        addr = 8'h21; din = 8'h33; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        repeat (5) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (100) @(negedge clk);
        check_eq("R2 busy stays low", int'(busy), 0);
        read_chk("R2 no write", 8'h21);

        // R8, R6: single byte, neighbours untouched.
        wr(8'h12, 8'h5A);
        check_eq("R4 busy after first byte", int'(busy), 1);
        wait_idle();
        read_chk("R8 byte written", 8'h12);
        check_eq("R8 value", int'(rd_data), 8'h5A);
        read_chk("R8 neighbour", 8'h13);
        check_eq("R8 neighbour erased", int'(rd_data), 8'hFF);

        // R7: out of order loads and an overwrite in one window (R5).
        wr(8'h1D, 8'h11);
        wr(8'h1A, 8'h22);
        wr(8'h1F, 8'h33);
        wr(8'h1A, 8'h44);
        wait_idle();
        read_chk("R7 slot 5", 8'h1D);
        read_chk("R7 overwrite", 8'h1A);
        check_eq("R7 overwrite value", int'(rd_data), 8'h44);
        read_chk("R7 slot 7", 8'h1F);
        read_chk("R8 unloaded slot", 8'h18);

        // R3: address changes after capture, data changes before release.
        @(negedge clk);
        addr = 8'h29; din = 8'h01; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (5) @(negedge clk);
        addr = 8'h2E; din = 8'hC3;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (4) @(negedge clk);
        wait_idle();
        read_chk("R3 address from falling strobe", 8'h29);
        check_eq("R3 data from rising strobe", int'(rd_data), 8'hC3);
        read_chk("R3 late address ignored", 8'h2E);

        // R5, R10: the window lapses, then a strobe during programming is dropped.
        wr(8'h31, 8'h77);
        repeat (LTO) @(negedge clk);
        check_eq("R5 busy in programming", int'(busy), 1);
        wr(8'h32, 8'h88);
        wait_idle();
        read_chk("R5 first byte committed", 8'h31);
        read_chk("R10 strobe in programming ignored", 8'h32);
        check_eq("R10 value", int'(rd_data), 8'hFF);

        // R9: wrong page byte dropped, flag sticky.
        wr(8'h40, 8'hA0);
        wr(8'h49, 8'hB1);
        check_eq("R9 page_err set", int'(page_err), 1);
        wait_idle();
        read_chk("R9 wrong page untouched", 8'h49);
        read_chk("R9 same slot untouched", 8'h41);
        read_chk("R9 good byte written", 8'h40);

        // R11: a read strobe while busy is a poll; when idle it is not.
        wr(8'h50, 8'h5C);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (4) @(negedge clk);
        check_eq("R11 poll while busy", int'(poll), 1);
        ce_n = 1'b1; oe_n = 1'b1;
        wait_idle();
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        check_eq("R11 no poll when idle", int'(poll), 0);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);

        // R12: full page.
        for (int i = 0; i < PG; i++) wr(8'h70 + i, 8'h90 + 3 * i);
        wait_idle();
        for (int i = 0; i < PG; i++) read_chk("R12 full page", 8'h70 + i);
        check_eq("R9 flag still set", int'(page_err), 1);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule